// File: doc/BRIEF.md
# Framed Serial Word Deserializer

This block turns a serial bit stream into parallel 24-bit words. The sender forwards its bit clock along with the data. That clock drives the block's only clock, so no local reference clock is needed. A one-cycle framing flag travels with the data and marks the first bit of each word. Bits arrive most significant first. Once 24 bits have been collected after a flag, the word is complete. The block then publishes the word on a parallel bus and pulses an active-low word strobe.

The strobe timing is fixed in bit clocks. It falls 6 bit clocks after the last bit of the word is sampled, and it stays low for 13 bit clocks. The parallel bus changes on the same edge as the falling strobe. It then holds its value until the next completed word. If the sender runs its bit clock faster than its word rate, filler bits appear between words without a flag. These bits are dropped, so the strobe period follows the word rate and its high time grows. A flag that arrives before a word is complete abandons that word.

A direction input selects the mode. Low means receive. High parks the receiver: capture stops, and the strobe stays high.

Top module: `word_deser`

## Requirements
- R1: While `dir_i` is 1 the receiver is disabled: `frame_i` and `ser_d_i` are ignored, `strobe_n_o` is 1 from the next cycle on, and `word_o` does not change.
- R2: With `dir_i` at 0, the bit sampled with `frame_i`=1 becomes `word_o[23]`, and each of the following 23 bit clocks fills the next lower bit down to `word_o[0]`.
- R3: `strobe_n_o` falls exactly 6 bit clocks after the clock edge that samples the 24th bit, and `word_o` takes the new word on that same edge.
- R4: Once low, `strobe_n_o` stays low for exactly 13 bit clocks and then returns to 1.
- R5: After reset `strobe_n_o` is 1 and `word_o` is 0. No strobe pulse occurs unless a complete 24-bit word was framed.
- R6: `word_o` changes only on the edge where `strobe_n_o` falls.
- R7: Bits that follow a completed word while `frame_i` is 0 are ignored and do not alter the next framed word.
- R8: If `frame_i` is 1 before 24 bits are collected, the partial word is dropped with no strobe, and a new word starts with that bit.
- R9: Words may follow each other with no gap (a new flag on the clock after the 24th bit). Each word gets its own strobe, 24 bit clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded bit clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | Mode select: 0 = receive, 1 = receiver parked |
| ser_d_i | input | 1 | Serial data bit |
| frame_i | input | 1 | Word start flag, high with the first bit of a word |
| word_o | output | 24 | Last completed word |
| strobe_n_o | output | 1 | Active-low word strobe |

## Verification
The bench targets several boundary cases. It sends back-to-back words, where a design that clears its shift state at the next flag would lose the pending word. It sends words separated by filler bits, where a design that keeps counting would shift garbage into the next word or emit extra strobes. It sends a flag partway through a word and one on the 24th bit; a wrong design would strobe a truncated word or misalign the next one. It also drives framed traffic with the direction input high, which must produce no strobe and leave the bus unchanged. The fall time and low width are measured against bench-side edge counts, so an off-by-one in either delay is caught.

// File: rtl/deser_pkg.sv
package deser_pkg;

    localparam int WORD_W   = 24;
    localparam int FALL_DLY = 6;
    localparam int LOW_LEN  = 13;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LOW
    } stb_state_e;

    // Bits needed to hold values 0..n
    function automatic int cnt_bits(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/word_collect.sv
module word_collect
    import deser_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         ser_d,
    input  logic         frame,
    output logic         done_o,
    output logic [W-1:0] word_o
);
    localparam int CW = cnt_bits(W);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic [W-1:0]  sr;
    } coll_t;

    coll_t q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            q <= '0;
        end else begin
            q.sr <= {q.sr[W-2:0], ser_d};
            if (frame) begin
                // A new flag always restarts, dropping any partial word
                q.active <= 1'b1;
                q.cnt    <= CW'(1);
            end else if (q.active) begin
                q.cnt <= q.cnt + CW'(1);
                if (q.cnt == CW'(W - 1)) begin
                    q.active <= 1'b0;
                end
            end
        end
    end

    assign done_o = en && q.active && !frame && (q.cnt == CW'(W - 1));
    assign word_o = {q.sr[W-2:0], ser_d};

endmodule

// File: rtl/word_strobe.sv
module word_strobe
    import deser_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int DLY   = FALL_DLY,
    parameter int LOWN  = LOW_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         done,
    input  logic [W-1:0] word_in,
    output logic         strobe_n_o,
    output logic [W-1:0] word_o
);
    localparam int TW = cnt_bits(max2(DLY, LOWN));

    typedef struct packed {
        stb_state_e    st;
        logic [TW-1:0] cnt;
        logic [W-1:0]  stage;
        logic [W-1:0]  out;
        logic          stb_n;
    } stb_t;

    stb_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st    <= ST_IDLE;
            q.cnt   <= '0;
            q.stage <= '0;
            q.out   <= '0;
            q.stb_n <= 1'b1;
        end else if (!en) begin
            q.st    <= ST_IDLE;
            q.cnt   <= '0;
            q.stb_n <= 1'b1;
        end else if (done) begin
            q.stage <= word_in;
            q.st    <= ST_WAIT;
            q.cnt   <= TW'(DLY - 1);
            q.stb_n <= 1'b1;
        end else begin
            case (q.st)
                ST_WAIT: begin
                    if (q.cnt == '0) begin
                        q.st    <= ST_LOW;
                        q.cnt   <= TW'(LOWN - 1);
                        q.stb_n <= 1'b0;
                        q.out   <= q.stage;
                    end else begin
                        q.cnt <= q.cnt - TW'(1);
                    end
                end
                ST_LOW: begin
                    if (q.cnt == '0) begin
                        q.st    <= ST_IDLE;
                        q.stb_n <= 1'b1;
                    end else begin
                        q.cnt <= q.cnt - TW'(1);
                    end
                end
                default: begin
                    q.stb_n <= 1'b1;
                end
            endcase
        end
    end

    assign strobe_n_o = q.stb_n;
    assign word_o     = q.out;

endmodule

// File: rtl/word_deser.sv
module word_deser
    import deser_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int DLY  = FALL_DLY,
    parameter int LOWN = LOW_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_i,
    input  logic         ser_d_i,
    input  logic         frame_i,
    output logic [W-1:0] word_o,
    output logic         strobe_n_o
);
    logic         rx_en;
    logic         done_w;
    logic [W-1:0] coll_word;

    assign rx_en = ~dir_i;

    word_collect #(.W(W)) u_collect (
        .clk    (clk),
        .rst    (rst),
        .en     (rx_en),
        .ser_d  (ser_d_i),
        .frame  (frame_i),
        .done_o (done_w),
        .word_o (coll_word)
    );

    word_strobe #(.W(W), .DLY(DLY), .LOWN(LOWN)) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .en         (rx_en),
        .done       (done_w),
        .word_in    (coll_word),
        .strobe_n_o (strobe_n_o),
        .word_o     (word_o)
    );

endmodule

// File: rtl/word_deser_chk.sv
module word_deser_chk #(
    parameter int W    = 24,
    parameter int DLY  = 6,
    parameter int LOWN = 13
) (
    input logic         clk,
    input logic         rst,
    input logic         dir_i,
    input logic         strobe_n_o,
    input logic [W-1:0] word_o,
    input logic         done
);
    logic [7:0] low_cnt;
    logic [7:0] since_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt    <= '0;
            since_done <= 8'hFF;
        end else begin
            if (!strobe_n_o) begin
                low_cnt <= (low_cnt == 8'hFF) ? low_cnt : low_cnt + 8'd1;
            end else begin
                low_cnt <= '0;
            end
            if (done) begin
                since_done <= '0;
            end else if (since_done != 8'hFF) begin
                since_done <= since_done + 8'd1;
            end
        end
    end

    p_park_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        dir_i |=> strobe_n_o);

    p_park_no_word_r1: assert property (@(posedge clk) disable iff (rst)
        dir_i |-> !done);

    p_fall_delay_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_n_o) |-> (since_done == 8'(DLY)));

    p_low_width_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_n_o) |-> (low_cnt == 8'(LOWN)));

    p_hold_word_r6: assert property (@(posedge clk) disable iff (rst)
        !$fell(strobe_n_o) |-> $stable(word_o));

endmodule

bind word_deser word_deser_chk #(.W(W), .DLY(DLY), .LOWN(LOWN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dir_i      (dir_i),
    .strobe_n_o (strobe_n_o),
    .word_o     (word_o),
    .done       (done_w)
);

// File: tb/word_deser_test.sv
`timescale 1ns/1ps
module word_deser_test;
    localparam int W    = 24;
    localparam int DLY  = 6;
    localparam int LOWN = 13;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         dir_i = 1'b0;
    logic         ser_d_i = 1'b0;
    logic         frame_i = 1'b0;
    logic [W-1:0] word_o;
    logic         strobe_n_o;

    int checks = 0;
    int errors = 0;
    int ecnt   = 0;

    typedef struct {
        logic [W-1:0] word;
        int           edge_no;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) ecnt <= ecnt + 1;

    word_deser #(.W(W), .DLY(DLY), .LOWN(LOWN)) uut (
        .clk        (clk),
        .rst        (rst),
        .dir_i      (dir_i),
        .ser_d_i    (ser_d_i),
        .frame_i    (frame_i),
        .word_o     (word_o),
        .strobe_n_o (strobe_n_o)
    );

    // Driver: one framed word, MSB first; push expectation when it counts
    task automatic send_bits(input logic [W-1:0] w, input int nbits, input bit expect_it);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            frame_i = (i == 0);
            ser_d_i = w[W-1-i];
            if (i == 0 && expect_it) begin
                exp_t e;
                e.word    = w;
                e.edge_no = ecnt + W + DLY;
                exp_q.push_back(e);
            end
        end
    endtask

    task automatic send_idle(input int n, input logic [W-1:0] pat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_i = 1'b0;
            ser_d_i = pat[i % W];
        end
    endtask

    // Monitor / scoreboard
    logic         prev_stb  = 1'b1;
    logic [W-1:0] prev_word = '0;
    int           low_samples = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stb && !strobe_n_o) begin
                low_samples = 1;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R5: unexpected strobe, word %h, expected none", word_o);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (ecnt != e.edge_no) begin
                        errors++;
                        $display("FAIL R3: strobe fell at edge %0d, expected %0d", ecnt, e.edge_no);
                    end
                    checks++;
                    if (word_o !== e.word) begin
                        errors++;
                        $display("FAIL R2: word %h, expected %h", word_o, e.word);
                    end
                end
            end else begin
                if (!strobe_n_o) low_samples++;
                if (!prev_stb && strobe_n_o) begin
                    checks++;
                    if (low_samples != LOWN) begin
                        errors++;
                        $display("FAIL R4: low width %0d, expected %0d", low_samples, LOWN);
                    end
                end
                if (word_o !== prev_word) begin
                    checks++;
                    errors++;
                    $display("FAIL R6: word changed to %h without strobe, expected %h", word_o, prev_word);
                end
            end
            prev_stb  = strobe_n_o;
            prev_word = word_o;
        end
    end

    task automatic expect_true(input bit cond, input string tag, input int act, input int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0h, expected %0h", tag, act, expv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5: reset state
        expect_true(strobe_n_o === 1'b1, "R5 reset strobe", int'(strobe_n_o), 1);
        expect_true(word_o === '0, "R5 reset word", int'(word_o), 0);

        // R5: unframed traffic gives no strobe
        send_idle(60, 24'hA5F00F);
        expect_true(strobe_n_o === 1'b1, "R5 no frame", int'(strobe_n_o), 1);

        // R2/R3/R4: single word, then R9 back-to-back words
        send_bits(24'hC3A511, W, 1'b1);
        send_bits(24'h800001, W, 1'b1);
        send_bits(24'h7FFFFE, W, 1'b1);
        send_bits(24'h123456, W, 1'b1);

        // R7: filler bits between words
        send_idle(17, 24'hFFFFFF);
        send_bits(24'h0F0F0F, W, 1'b1);
        send_idle(40, 24'h5A5A5A);
        send_bits(24'hFEDCBA, W, 1'b1);
        send_idle(50, 24'h000000);

        // R8: early flag aborts partial word; also flag on the 24th bit
        send_bits(24'hAAAAAA, 10, 1'b0);
        send_bits(24'h13579B, W, 1'b1);
        send_idle(40, 24'hFFFFFF);
        send_bits(24'h555555, W - 1, 1'b0);
        send_bits(24'h2468AC, W, 1'b1);
        send_idle(50, 24'h0);

        // R1: parked receiver ignores framed traffic
        held = word_o;
        @(negedge clk);
        dir_i = 1'b1;
        send_bits(24'hDEADBE, W, 1'b0);
        send_idle(30, 24'hFFFFFF);
        expect_true(strobe_n_o === 1'b1, "R1 parked strobe", int'(strobe_n_o), 1);
        expect_true(word_o === held, "R1 parked word", int'(word_o), int'(held));
        @(negedge clk);
        dir_i = 1'b0;
        send_idle(5, 24'h0);
        send_bits(24'hBEEF01, W, 1'b1);
        send_idle(60, 24'h0);

        // R3: every expected strobe arrived
        expect_true(exp_q.size() == 0, "R3 missing strobes", exp_q.size(), 0);
        expect_true(word_o === 24'hBEEF01, "R2 final word", int'(word_o), 24'hBEEF01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule